// File: doc/BRIEF.md
# Frame-Based Audio Gain Controller

This block sets the gain of an external programmable amplifier that sits in front of a 10-bit audio converter. It looks at each converter sample and removes the mid-scale offset. Over one audio frame it keeps the largest magnitude it has seen. At each frame strobe it sorts the finished frame into one of three classes: quiet, loud or in range. It then decides whether the 3-bit gain code should move by one step.

Gain falls quickly when frames are loud. It rises slowly when frames are quiet, and only after a hold period plus an extra pause latency, both counted in frames. This keeps background noise in speech pauses from being pumped up. The gain code only moves on the clock edge that closes a frame, so the relative amplitudes inside a frame are preserved.

A force input pins the code at maximum gain. It is used for short standby probes and freezes all decision state while it is asserted.

Top module: `frame_agc`

## Requirements
- R1: The frame statistic is the largest |sample − 512| over all valid samples of the frame, with 10-bit unsigned samples. A sample arriving together with the frame strobe belongs to the closing frame. The statistic restarts from zero for the next frame.
- R2: A frame is loud when its statistic is ≥ `thr_high`. It is quiet when its statistic is < `thr_low` and it is not loud. Any other frame is in range: it leaves the gain unchanged and clears both the quiet and the loud run.
- R3: `gain_code` changes only on the clock edge at which `frame_end` is sampled high, and by exactly one step. Code k means an amplifier gain of 6·(k+1) dB, so code 0 is 6 dB and code 7 is 48 dB.
- R4: Within a run of consecutive quiet frames, no increase happens before quiet frame number `hold_frames + pause_frames + 1`.
- R5: From the first eligible quiet frame on, the gain rises by one step every `up_rate` quiet frames. The first eligible frame steps only if the up pacer is at phase zero. A value of 0 acts as 1.
- R6: The first frame of a loud run lowers the gain at once. After that, the gain falls one step every `dn_rate` loud frames. A value of 0 acts as 1.
- R7: The gain saturates at codes 0 and 7. A step beyond either end is dropped without wrapping.
- R8: While `force_max` is high, `gain_code` reads 7 in the same cycle. All run and rate state is frozen, and frame strobes are not acted on. On release, the code returns to the value it held before the force.
- R9: After reset, `gain_code` is 0 and `level_vld` is 0.
- R10: `level_vld` rises on the edge that closes the first frame after reset and stays high. It does so even while `force_max` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 10 | Unsigned converter sample, mid-scale 512 |
| frame_end | input | 1 | Frame boundary strobe |
| thr_low | input | 10 | Quiet threshold on the frame peak |
| thr_high | input | 10 | Loud threshold on the frame peak |
| hold_frames | input | 8 | Hold time before a rise, in frames |
| pause_frames | input | 8 | Extra quiet latency before a rise, in frames |
| up_rate | input | 8 | Frames per step when rising |
| dn_rate | input | 8 | Frames per step when falling |
| force_max | input | 1 | Force maximum gain, freeze state |
| gain_code | output | 3 | Gain code to the amplifier |
| level_vld | output | 1 | At least one frame has been measured |

## Verification
Every internal counter in this block shows up only as the frame in which `gain_code` next moves. A quiet-run count that is off by one moves the first rise one frame early or late. A pacer phase that is not frozen during a force shows up as a down step on the wrong loud frame after release. A peak that is not cleared leaves the gain stuck for the frame after a loud one. The bench therefore checks the code after every single frame, so any such fault appears within one frame of its cause. The checks also cover threshold equality and saturation at both ends.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    FC_MID   = 2'd0,
    FC_QUIET = 2'd1,
    FC_LOUD  = 2'd2
  } frame_class_e;
endpackage

// File: rtl/agc_peak_meter.sv
module agc_peak_meter #(
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             frame_end,
  output logic [SMP_W-1:0] frame_peak
);
  localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1);

  logic [SMP_W-1:0] mag;
  logic [SMP_W-1:0] acc_q, acc_d;
  logic             take;

  always_comb begin
    if (smp_data >= MID) mag = smp_data - MID;
    else                 mag = MID - smp_data;
  end

  assign take       = smp_vld && (mag > acc_q);
  assign frame_peak = take ? mag : acc_q;

  always_comb begin
    acc_d = acc_q;
    if (frame_end) acc_d = '0;
    else if (take) acc_d = mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R1: the running peak is a magnitude about mid-scale and can never pass it
  assert_peak_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= MID);
  // R1: the accumulator restarts at each frame boundary
  assert_peak_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> acc_q == '0);
endmodule

// File: rtl/agc_rate_pacer.sv
module agc_rate_pacer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [CNT_W-1:0] rate,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   rate_eff;

  assign rate_eff = (rate == '0) ? (CNT_W+1)'(1) : {1'b0, rate};
  assign cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign fire     = tick && active && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (!active)               cnt_d = '0;
      else if (cnt_inc >= rate_eff) cnt_d = '0;
      else                       cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: pacing phase moves only on an accepted frame tick
  assert_phase_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/frame_agc.sv
module frame_agc #(
  parameter int SMP_W  = 10,
  parameter int GAIN_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              frame_end,
  input  logic [SMP_W-1:0]  thr_low,
  input  logic [SMP_W-1:0]  thr_high,
  input  logic [CNT_W-1:0]  hold_frames,
  input  logic [CNT_W-1:0]  pause_frames,
  input  logic [CNT_W-1:0]  up_rate,
  input  logic [CNT_W-1:0]  dn_rate,
  input  logic              force_max,
  output logic [GAIN_W-1:0] gain_code,
  output logic              level_vld
);
  import agc_pkg::*;

  localparam logic [GAIN_W-1:0] GMAX = '1;
  localparam logic [CNT_W:0]    RUN_SAT = '1;

  logic [SMP_W-1:0]  frame_peak;
  frame_class_e      cls;
  logic              tick;
  logic              up_fire, dn_fire, up_active;
  logic [CNT_W:0]    qrun_q, qrun_d;
  logic [CNT_W+1:0]  qrun_inc, wait_frames;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              lvl_q, lvl_d;

  agc_peak_meter #(.SMP_W(SMP_W)) peak_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .frame_end(frame_end), .frame_peak(frame_peak)
  );

  always_comb begin
    if (frame_peak >= thr_high)    cls = FC_LOUD;
    else if (frame_peak < thr_low) cls = FC_QUIET;
    else                           cls = FC_MID;
  end

  assign tick        = frame_end && !force_max;
  assign qrun_inc    = {1'b0, qrun_q} + (CNT_W+2)'(1);
  assign wait_frames = (CNT_W+2)'(hold_frames) + (CNT_W+2)'(pause_frames);
  assign up_active   = (cls == FC_QUIET) && (qrun_inc > wait_frames);

  agc_rate_pacer #(.CNT_W(CNT_W)) up_pacer_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(up_active),
    .rate(up_rate), .fire(up_fire)
  );

  agc_rate_pacer #(.CNT_W(CNT_W)) dn_pacer_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(cls == FC_LOUD),
    .rate(dn_rate), .fire(dn_fire)
  );

  always_comb begin
    qrun_d = qrun_q;
    gain_d = gain_q;
    lvl_d  = lvl_q || frame_end;
    if (tick) begin
      if (cls != FC_QUIET)       qrun_d = '0;
      else if (qrun_q != RUN_SAT) qrun_d = qrun_inc[CNT_W:0];
      if (dn_fire && gain_q != '0)        gain_d = gain_q - GAIN_W'(1);
      else if (up_fire && gain_q != GMAX) gain_d = gain_q + GAIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qrun_q <= '0;
      gain_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      qrun_q <= qrun_d;
      gain_q <= gain_d;
      lvl_q  <= lvl_d;
    end
  end

  assign gain_code = force_max ? GMAX : gain_q;
  assign level_vld = lvl_q;

  // R3: the stored gain moves only on the edge closing a frame
  assert_frame_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_q) |-> $past(tick));
  // R3: one step at a time
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_q) |-> (gain_q == GAIN_W'($past(gain_q) + 1'b1) ||
                          gain_q == GAIN_W'($past(gain_q) - 1'b1)));
  // R7: no wrap at the top
  assert_no_wrap_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gain_q) == GMAX |-> gain_q != '0);
  // R7: no wrap at the bottom
  assert_no_wrap_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gain_q) == '0 |-> gain_q != GMAX);
  // R4: a rise follows only a quiet frame
  assert_rise_needs_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q > $past(gain_q)) |-> $past(cls == FC_QUIET));
  // R8: forcing freezes the stored gain
  assert_force_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_max |=> $stable(gain_q));
  // R10: once valid, the level flag stays high
  assert_level_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q |=> lvl_q);
endmodule

// File: tb/frame_agc_tb.sv
module frame_agc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_vld, frame_end, force_max;
  logic [9:0] smp_data, thr_low, thr_high;
  logic [7:0] hold_frames, pause_frames, up_rate, dn_rate;
  logic [2:0] gain_code;
  logic       level_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_agc dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .frame_end(frame_end), .thr_low(thr_low), .thr_high(thr_high),
    .hold_frames(hold_frames), .pause_frames(pause_frames),
    .up_rate(up_rate), .dn_rate(dn_rate), .force_max(force_max),
    .gain_code(gain_code), .level_vld(level_vld)
  );

  // {negative side, peak magnitude, expected gain after the frame}
  localparam logic [13:0] VEC [16] = '{
    {1'b0, 10'd50,  3'd0}, {1'b1, 10'd50,  3'd0}, {1'b0, 10'd50,  3'd0},
    {1'b1, 10'd50,  3'd1}, {1'b0, 10'd50,  3'd1}, {1'b0, 10'd50,  3'd1},
    {1'b1, 10'd50,  3'd2}, {1'b0, 10'd450, 3'd1}, {1'b1, 10'd400, 3'd0},
    {1'b0, 10'd450, 3'd0}, {1'b1, 10'd250, 3'd0}, {1'b0, 10'd100, 3'd0},
    {1'b1, 10'd99,  3'd0}, {1'b0, 10'd99,  3'd0}, {1'b0, 10'd99,  3'd0},
    {1'b1, 10'd99,  3'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [9:0] mag, input logic neg);
    @(negedge clk); smp_vld = 1'b1; smp_data = 10'd512;
    @(negedge clk); smp_data = 10'(10'd512 + (mag >> 1));
    @(negedge clk); smp_data = neg ? 10'(10'd512 - mag) : 10'(10'd512 + mag);
    @(negedge clk); smp_vld = 1'b0; frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; frame_end = 1'b0; force_max = 1'b0;
    smp_data = 10'd512; thr_low = 10'd100; thr_high = 10'd400;
    hold_frames = 8'd2; pause_frames = 8'd1; up_rate = 8'd3; dn_rate = 8'd1;
    repeat (3) @(negedge clk);
    check("R9 gain after reset", gain_code, 0);
    check("R9 level_vld after reset", level_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 level_vld before first frame", level_vld, 0);

    // R1 R2 R4 R5 R6 R7: per-frame table
    foreach (VEC[i]) begin
      run_frame(VEC[i][12:3], VEC[i][13]);
      check($sformatf("R4/R5/R6 table frame %0d", i), gain_code, VEC[i][2:0]);
      if (i == 0) check("R10 level_vld after first frame", level_vld, 1);
    end

    // R5 with rate 1, then saturation at the top (R7)
    hold_frames = 8'd0; pause_frames = 8'd0; up_rate = 8'd1;
    run_frame(10'd20, 1'b0);
    check("R5 pacer phase nonzero, no step", gain_code, 1);
    for (int k = 2; k <= 7; k++) begin
      run_frame(10'd20, 1'b1);
      check("R5 step every quiet frame", gain_code, k);
    end
    run_frame(10'd20, 1'b0);
    check("R7 saturate at top", gain_code, 7);

    // R6 with rate 2
    dn_rate = 8'd2;
    run_frame(10'd500, 1'b0);
    check("R6 first loud frame steps", gain_code, 6);
    run_frame(10'd500, 1'b1);
    check("R6 second loud frame holds", gain_code, 6);
    run_frame(10'd512, 1'b1);
    check("R6 third loud frame steps", gain_code, 5);

    // R8 force and freeze
    @(negedge clk); force_max = 1'b1;
    #1 check("R8 forced code immediate", gain_code, 7);
    run_frame(10'd500, 1'b0);
    run_frame(10'd500, 1'b0);
    check("R8 forced during loud frames", gain_code, 7);
    @(negedge clk); force_max = 1'b0;
    #1 check("R8 release restores code", gain_code, 5);
    run_frame(10'd500, 1'b0);
    check("R8 down phase frozen, no step", gain_code, 5);
    run_frame(10'd500, 1'b0);
    check("R8 down phase resumes", gain_code, 4);

    // R6 rate 0 acts as 1
    dn_rate = 8'd0;
    run_frame(10'd500, 1'b0);
    check("R6 rate0 phase wrap", gain_code, 4);
    run_frame(10'd500, 1'b0);
    check("R6 rate0 step", gain_code, 3);
    run_frame(10'd500, 1'b0);
    check("R6 rate0 step again", gain_code, 2);

    // R2 in-range frame leaves gain alone
    run_frame(10'd399, 1'b0);
    check("R2 in-range just below high", gain_code, 2);

    // R9 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1 check("R9 gain in reset", gain_code, 0);
    check("R9 level_vld in reset", level_vld, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule